// File: doc/BRIEF.md
# Common Interrupt Distributor

This block sits between a set of shared, chip-level interrupt sources and the interrupt controllers of several processor cores. Each shared source has its own small configuration: a set of eligible cores, a distribution style, a trigger style and a mask. Software writes this configuration through a single command port. Each command carries an opcode, the index of a shared interrupt and a 32-bit data word. A global enable command opens the block. Until that command arrives, no core sees any interrupt.

There are two distribution styles. In fixed-target style, an interrupt goes to the cores named in its core set. In rotating style, successive assertions are spread over the named cores in turn, which balances load. The trigger style selects between two behaviours. A level interrupt is held on the chosen core for as long as the source stays asserted. An edge interrupt produces a one-cycle pulse when the source rises. Each core receives shared interrupt n on its local line number `LINE_BASE + n`, and `LINE_BASE` is 24 by default. Every output is registered, so it follows the sampled inputs by one clock.

Top module: `cidu_top`

## Requirements
- R1: After reset, all core lines are 0. Every shared interrupt resets to masked, with core set 0b0001 (core 0 only), fixed-target style and level trigger, and the global enable resets to off.
- R2: Before a global-enable command has taken effect, no core line is ever asserted, whatever the sources do.
- R3: Shared interrupt n appears only on line `LINE_BASE+n` of each core (bit `c*CORE_LINES + LINE_BASE + n` of `core_irq`). All other lines stay 0.
- R4: In fixed-target style with edge trigger, a rising eligible source produces exactly one cycle of assertion on every core in the core set. The pulse appears one clock after the rise is sampled.
- R5: In fixed-target style with level trigger, only the lowest-numbered core in the set is driven, and it follows the eligible source with one clock of latency.
- R6: In rotating style, each new eligible assertion goes to the next core in the set after the one used last for that interrupt, wrapping to the lowest index. After reset, the first assertion goes to the lowest set core.
- R7: In rotating style with level trigger, the chosen core keeps the line until the source is deasserted or masked, even if the core set changes meanwhile.
- R8: A set-mask command with data bit 0 = 1 masks the interrupt, and bit 0 = 0 unmasks it. A masked interrupt delivers nothing and does not advance the rotation. Unmasking while the source is high counts as a new assertion.
- R9: In the mode word, bits [1:0] = 2'b00 select rotating style and any other value selects fixed-target style. Bit 4 = 1 selects level trigger and bit 4 = 0 selects edge trigger. All other bits are ignored.
- R10: The opcodes are 1 = global enable, 2 = set core set (data bits [N_CORE-1:0]), 3 = set mode, and 4 = set mask. Any other opcode, or any command with `cmd_valid` low, has no effect. A command takes effect from the clock after it is sampled.
- R11: An empty core set delivers nothing, and in rotating style it leaves the rotation position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | IDX_W | Shared interrupt index |
| cmd_data | input | 32 | Command data word |
| irq_src | input | N_IRQ | Shared interrupt sources, active high |
| core_irq | output | N_CORE*CORE_LINES | Per-core interrupt lines, core c at bits [c*CORE_LINES +: CORE_LINES] |

## Verification
The bench drives rotation across a sparse core set that wraps past the top core. A design with a wrong scan start or a wrong wrap would repeat a core or skip one. A masked assertion is placed in the middle of a rotation. A design that advanced its pointer while masked would deliver the next interrupt to the wrong core. The bench also feeds mode words full of ignored bits and opcodes that are not defined. A design that decoded too many bits would change style or trigger. A level interrupt with a multi-core set must light exactly one core, and an empty set must stay silent without disturbing the rotation.

// File: rtl/cidu_pkg.sv
package cidu_pkg;
   localparam int DATA_W   = 32;
   localparam int OP_W     = 3;
   localparam int TRIG_BIT = 4;
   localparam logic [1:0] DISTR_ROTATE = 2'b00;

   typedef enum logic [OP_W-1:0] {
      OP_NONE     = 3'd0,
      OP_ENABLE   = 3'd1,
      OP_SET_DEST = 3'd2,
      OP_SET_MODE = 3'd3,
      OP_SET_MASK = 3'd4
   } cidu_op_e;
endpackage

// File: rtl/cidu_cfg_regs.sv
module cidu_cfg_regs
   import cidu_pkg::*;
#(
   parameter int N_IRQ  = 8,
   parameter int N_CORE = 4,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [OP_W-1:0]         cmd_op,
   input  logic [IDX_W-1:0]        cmd_idx,
   input  logic [DATA_W-1:0]       cmd_data,
   output logic                    glob_en,
   output logic [N_IRQ*N_CORE-1:0] dest,
   output logic [N_IRQ-1:0]        rotate,
   output logic [N_IRQ-1:0]        level,
   output logic [N_IRQ-1:0]        masked
);
   cidu_op_e op;
   assign op = cidu_op_e'(cmd_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             glob_en <= 1'b0;
      else if (cmd_valid && op == OP_ENABLE)  glob_en <= 1'b1;
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      logic              hit;
      logic [N_CORE-1:0] dest_q;
      logic              rot_q;
      logic              lvl_q;
      logic              msk_q;

      assign hit = cmd_valid && (cmd_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dest_q <= N_CORE'(1);
            rot_q  <= 1'b0;
            lvl_q  <= 1'b1;
            msk_q  <= 1'b1;
         end else if (hit) begin
            case (op)
               OP_SET_DEST: dest_q <= cmd_data[N_CORE-1:0];
               OP_SET_MODE: begin
                  rot_q <= (cmd_data[1:0] == DISTR_ROTATE);
                  lvl_q <= cmd_data[TRIG_BIT];
               end
               OP_SET_MASK: msk_q <= cmd_data[0];
               default: ;
            endcase
         end
      end

      assign dest[i*N_CORE +: N_CORE] = dest_q;
      assign rotate[i] = rot_q;
      assign level[i]  = lvl_q;
      assign masked[i] = msk_q;
   end
endmodule

// File: rtl/cidu_route_slice.sv
module cidu_route_slice #(
   parameter int N_CORE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic              src,
   input  logic [N_CORE-1:0] dest,
   input  logic              rotate,
   input  logic              level,
   input  logic              masked,
   output logic [N_CORE-1:0] deliver
);
   localparam int CW = (N_CORE > 1) ? $clog2(N_CORE) : 1;

   logic              elig;
   logic              elig_q;
   logic              rise;
   logic [N_CORE-1:0] hold_q, hold_n;
   logic [CW-1:0]     last_q, last_n;
   logic [N_CORE-1:0] pick;
   logic [CW-1:0]     pick_idx;
   logic              pick_ok;
   logic [N_CORE-1:0] lowest;
   logic [N_CORE-1:0] nxt;
   int unsigned       scan;

   assign elig   = src && !masked && glob_en;
   assign rise   = elig && !elig_q;
   assign lowest = dest & (~dest + N_CORE'(1));

   // next set core strictly after last_q, wrapping
   always_comb begin
      pick     = '0;
      pick_idx = last_q;
      pick_ok  = 1'b0;
      scan     = 0;
      for (int k = 1; k <= N_CORE; k++) begin
         scan = int'(last_q) + k;
         if (scan >= N_CORE) scan = scan - N_CORE;
         if (!pick_ok && dest[scan]) begin
            pick_ok    = 1'b1;
            pick[scan] = 1'b1;
            pick_idx   = CW'(scan);
         end
      end
   end

   always_comb begin
      nxt    = '0;
      hold_n = hold_q;
      last_n = last_q;
      if (!rotate || !elig) hold_n = '0;
      if (rotate) begin
         if (rise) begin
            nxt    = pick;
            hold_n = pick;
            if (pick_ok) last_n = pick_idx;
         end else if (level && elig) begin
            nxt = hold_q;
         end
      end else if (level) begin
         nxt = elig ? lowest : '0;
      end else begin
         nxt = rise ? dest : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elig_q  <= 1'b0;
         hold_q  <= '0;
         last_q  <= CW'(N_CORE - 1);
         deliver <= '0;
      end else begin
         elig_q  <= elig;
         hold_q  <= hold_n;
         last_q  <= last_n;
         deliver <= nxt;
      end
   end
endmodule

// File: rtl/cidu_core_map.sv
module cidu_core_map #(
   parameter int N_IRQ      = 8,
   parameter int N_CORE     = 4,
   parameter int CORE_LINES = 32,
   parameter int LINE_BASE  = 24
) (
   input  logic [N_IRQ*N_CORE-1:0]      deliver,
   output logic [N_CORE*CORE_LINES-1:0] core_irq
);
   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      for (genvar l = 0; l < CORE_LINES; l++) begin : g_line
         if (l >= LINE_BASE && l < LINE_BASE + N_IRQ) begin : g_used
            assign core_irq[c*CORE_LINES + l] = deliver[(l-LINE_BASE)*N_CORE + c];
         end else begin : g_spare
            assign core_irq[c*CORE_LINES + l] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/cidu_top.sv
module cidu_top
   import cidu_pkg::*;
#(
   parameter int N_IRQ      = 8,
   parameter int N_CORE     = 4,
   parameter int CORE_LINES = 32,
   parameter int LINE_BASE  = 24,
   localparam int IDX_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [2:0]                   cmd_op,
   input  logic [IDX_W-1:0]             cmd_idx,
   input  logic [31:0]                  cmd_data,
   input  logic [N_IRQ-1:0]             irq_src,
   output logic [N_CORE*CORE_LINES-1:0] core_irq
);
   if (N_CORE < 1 || N_CORE > DATA_W) begin : g_bad_cores
      $error("cidu_top: N_CORE must be 1..32");
   end
   if (N_IRQ < 1) begin : g_bad_irqs
      $error("cidu_top: N_IRQ must be at least 1");
   end
   if (LINE_BASE + N_IRQ > CORE_LINES) begin : g_bad_lines
      $error("cidu_top: shared lines exceed core line count");
   end

   logic                    glob_en;
   logic [N_IRQ*N_CORE-1:0] cfg_dest;
   logic [N_IRQ-1:0]        cfg_rotate;
   logic [N_IRQ-1:0]        cfg_level;
   logic [N_IRQ-1:0]        cfg_masked;
   logic [N_IRQ*N_CORE-1:0] deliver;

   cidu_cfg_regs #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .IDX_W(IDX_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_idx  (cmd_idx),
      .cmd_data (cmd_data),
      .glob_en  (glob_en),
      .dest     (cfg_dest),
      .rotate   (cfg_rotate),
      .level    (cfg_level),
      .masked   (cfg_masked)
   );

   for (genvar i = 0; i < N_IRQ; i++) begin : g_slice
      cidu_route_slice #(.N_CORE(N_CORE)) u_route (
         .clk    (clk),
         .rst_n  (rst_n),
         .glob_en(glob_en),
         .src    (irq_src[i]),
         .dest   (cfg_dest[i*N_CORE +: N_CORE]),
         .rotate (cfg_rotate[i]),
         .level  (cfg_level[i]),
         .masked (cfg_masked[i]),
         .deliver(deliver[i*N_CORE +: N_CORE])
      );
   end

   cidu_core_map #(
      .N_IRQ(N_IRQ), .N_CORE(N_CORE), .CORE_LINES(CORE_LINES), .LINE_BASE(LINE_BASE)
   ) u_map (
      .deliver (deliver),
      .core_irq(core_irq)
   );
endmodule

// File: rtl/cidu_checker.sv
module cidu_checker #(
   parameter int N_IRQ      = 8,
   parameter int N_CORE     = 4,
   parameter int CORE_LINES = 32,
   parameter int LINE_BASE  = 24
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cmd_valid,
   input logic [2:0]                   cmd_op,
   input logic [N_CORE*CORE_LINES-1:0] core_irq,
   input logic [N_IRQ-1:0]             rotate_cfg,
   input logic [N_IRQ-1:0]             level_cfg,
   input logic [N_IRQ-1:0]             masked_cfg
);
   logic en_seen, en_seen_d;
   logic [N_CORE*CORE_LINES-1:0] spare;
   logic [N_IRQ*N_CORE-1:0]      colf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_seen   <= 1'b0;
         en_seen_d <= 1'b0;
      end else begin
         if (cmd_valid && cmd_op == 3'd1) en_seen <= 1'b1;
         en_seen_d <= en_seen;
      end
   end

   always_comb begin
      spare = '0;
      for (int c = 0; c < N_CORE; c++)
         for (int l = 0; l < CORE_LINES; l++)
            if (l < LINE_BASE || l >= LINE_BASE + N_IRQ) spare[c*CORE_LINES + l] = core_irq[c*CORE_LINES + l];
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_col
      for (genvar c = 0; c < N_CORE; c++) begin : g_c
         assign colf[i*N_CORE + c] = core_irq[c*CORE_LINES + LINE_BASE + i];
      end
   end

   AST_QUIET_BEFORE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_seen_d |-> core_irq == '0); // R2
   AST_SPARE_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      spare == '0); // R3

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rotate_cfg[i]) || $past(level_cfg[i])) |-> $onehot0(colf[i*N_CORE +: N_CORE])); // R6
      AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         $past(masked_cfg[i]) |-> colf[i*N_CORE +: N_CORE] == '0); // R8
      AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(level_cfg[i]) && !level_cfg[i] && colf[i*N_CORE +: N_CORE] != '0)
         |=> colf[i*N_CORE +: N_CORE] == '0); // R4
   end
endmodule

bind cidu_top cidu_checker #(
   .N_IRQ(N_IRQ), .N_CORE(N_CORE), .CORE_LINES(CORE_LINES), .LINE_BASE(LINE_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .core_irq  (core_irq),
   .rotate_cfg(cfg_rotate),
   .level_cfg (cfg_level),
   .masked_cfg(cfg_masked)
);

// File: tb/sim_cidu_top.sv
module sim_cidu_top;
   localparam int NI = 8;
   localparam int NC = 4;
   localparam int LINES = 32;
   localparam int BASE = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [2:0]        cmd_op = '0;
   logic [2:0]        cmd_idx = '0;
   logic [31:0]       cmd_data = '0;
   logic [NI-1:0]     irq_src = '0;
   logic [NC*LINES-1:0] core_irq;

   int checks = 0;
   int errors = 0;
   string phase = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   cidu_top #(.N_IRQ(NI), .N_CORE(NC), .CORE_LINES(LINES), .LINE_BASE(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_src(irq_src), .core_irq(core_irq)
   );

   // behavioural reference model
   logic [NC-1:0]     m_dest [NI];
   bit                m_rot [NI];
   bit                m_lvl [NI];
   bit                m_msk [NI];
   bit                m_eq [NI];
   logic [NC-1:0]     m_hold [NI];
   int                m_last [NI];
   bit                m_en;
   logic [NC*LINES-1:0] exp_v;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0;
         exp_v = '0;
         for (int i = 0; i < NI; i++) begin
            m_dest[i] = 1; m_rot[i] = 0; m_lvl[i] = 1; m_msk[i] = 1;
            m_eq[i] = 0; m_hold[i] = 0; m_last[i] = NC - 1;
         end
      end else begin
         for (int i = 0; i < NI; i++) begin
            bit elig, rise, found;
            logic [NC-1:0] dl;
            elig = irq_src[i] && !m_msk[i] && m_en;
            rise = elig && !m_eq[i];
            dl = '0;
            if (!m_rot[i] || !elig) m_hold[i] = '0;
            if (m_rot[i]) begin
               if (rise) begin
                  found = 0;
                  for (int k = 1; k <= NC; k++) begin
                     int idx;
                     idx = (m_last[i] + k) % NC;
                     if (!found && m_dest[i][idx]) begin
                        found = 1; dl[idx] = 1'b1; m_last[i] = idx;
                     end
                  end
                  m_hold[i] = dl;
               end else if (m_lvl[i] && elig) dl = m_hold[i];
            end else if (m_lvl[i]) begin
               found = 0;
               if (elig)
                  for (int c = 0; c < NC; c++)
                     if (!found && m_dest[i][c]) begin found = 1; dl[c] = 1'b1; end
            end else if (rise) dl = m_dest[i];
            m_eq[i] = elig;
            for (int c = 0; c < NC; c++) exp_v[c*LINES + BASE + i] = dl[c];
         end
         if (cmd_valid) begin
            case (cmd_op)
               3'd1: m_en = 1;
               3'd2: m_dest[cmd_idx] = cmd_data[NC-1:0];
               3'd3: begin m_rot[cmd_idx] = (cmd_data[1:0] == 2'b00); m_lvl[cmd_idx] = cmd_data[4]; end
               3'd4: m_msk[cmd_idx] = cmd_data[0];
               default: ;
            endcase
         end
      end
   end

   // compare against the model every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (core_irq !== exp_v) begin
            errors++;
            $display("FAIL %s model compare: got %h expected %h", phase, core_irq, exp_v);
         end
      end
   end

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [NC-1:0] col(int i);
      for (int c = 0; c < NC; c++) col[c] = core_irq[c*LINES + BASE + i];
   endfunction

   task automatic cmd(logic [2:0] op, int idx, logic [31:0] data);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = 3'(idx); cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
   endtask

   // one assertion held for cyc cycles, expected on a single core
   task automatic rr_hit(string req, int i, logic [NC-1:0] exp, int cyc);
      irq_src[i] = 1'b1;
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk);
         check(req, 32'(col(i)), 32'(exp));
      end
      irq_src[i] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R1";
      check("R1", core_irq[31:0], 32'h0);
      check("R1", core_irq[127:96], 32'h0);

      phase = "R2";
      irq_src[0] = 1'b1;
      cmd(3'd4, 0, 0);
      repeat (2) @(negedge clk);
      check("R2", 32'(col(0)), 32'h0);

      phase = "R3";
      cmd(3'd1, 0, 0);
      @(negedge clk);
      check("R3", 32'(core_irq[BASE]), 32'h1);
      check("R3", 32'(core_irq[1*LINES + BASE]), 32'h0);
      check("R3", 32'(core_irq[BASE-1]), 32'h0);
      irq_src[0] = 1'b0;
      @(negedge clk);

      phase = "R5";
      cmd(3'd2, 1, 32'h6);
      cmd(3'd3, 1, 32'h11);
      cmd(3'd4, 1, 0);
      irq_src[1] = 1'b1;
      @(negedge clk);
      check("R5", 32'(col(1)), 32'h2);
      @(negedge clk);
      check("R5", 32'(col(1)), 32'h2);

      phase = "R9";
      cmd(3'd3, 1, 32'hFFFF_FFED);
      @(negedge clk);
      check("R9", 32'(col(1)), 32'h0);
      irq_src[1] = 1'b0;
      @(negedge clk);
      irq_src[1] = 1'b1;
      @(negedge clk);
      check("R9", 32'(col(1)), 32'h6);
      irq_src[1] = 1'b0;
      @(negedge clk);

      phase = "R4";
      cmd(3'd2, 5, 32'hB);
      cmd(3'd3, 5, 32'h01);
      cmd(3'd4, 5, 0);
      irq_src[5] = 1'b1;
      @(negedge clk);
      check("R4", 32'(col(5)), 32'hB);
      @(negedge clk);
      check("R4", 32'(col(5)), 32'h0);
      irq_src[5] = 1'b0;
      @(negedge clk);

      phase = "R6";
      cmd(3'd2, 2, 32'hD);
      cmd(3'd3, 2, 32'h10);
      cmd(3'd4, 2, 0);
      rr_hit("R6", 2, 4'b0001, 1);
      rr_hit("R6", 2, 4'b0100, 1);
      rr_hit("R6", 2, 4'b1000, 1);
      phase = "R7";
      rr_hit("R7", 2, 4'b0001, 3);
      irq_src[2] = 1'b1;
      @(negedge clk);
      cmd(3'd2, 2, 32'h8);
      check("R7", 32'(col(2)), 32'h4);
      @(negedge clk);
      check("R7", 32'(col(2)), 32'h4);
      irq_src[2] = 1'b0;
      @(negedge clk);
      cmd(3'd2, 2, 32'hD);

      phase = "R8";
      cmd(3'd4, 2, 1);
      rr_hit("R8", 2, 4'b0000, 2);
      cmd(3'd4, 2, 0);
      rr_hit("R8", 2, 4'b1000, 1);
      cmd(3'd4, 2, 1);
      irq_src[2] = 1'b1;
      @(negedge clk);
      check("R8", 32'(col(2)), 32'h0);
      cmd(3'd4, 2, 0);
      @(negedge clk);
      check("R8", 32'(col(2)), 32'h1);
      irq_src[2] = 1'b0;
      @(negedge clk);

      phase = "R9";
      cmd(3'd2, 3, 32'h3);
      cmd(3'd3, 3, 32'hFFFF_FFFC);
      cmd(3'd4, 3, 0);
      rr_hit("R9", 3, 4'b0001, 2);
      rr_hit("R9", 3, 4'b0010, 2);

      phase = "R10";
      cmd(3'd5, 3, 32'hFFFF_FFFF);
      cmd(3'd7, 3, 32'hFFFF_FFFF);
      cmd(3'd0, 3, 32'h0);
      cmd_op = 3'd2; cmd_idx = 3'd3; cmd_data = 32'h0;
      @(negedge clk);
      cmd_op = 3'd0;
      rr_hit("R10", 3, 4'b0001, 2);
      rr_hit("R10", 3, 4'b0010, 1);

      phase = "R11";
      cmd(3'd2, 4, 32'h0);
      cmd(3'd3, 4, 32'h10);
      cmd(3'd4, 4, 0);
      rr_hit("R11", 4, 4'b0000, 2);
      cmd(3'd2, 4, 32'h4);
      rr_hit("R11", 4, 4'b0100, 1);
      cmd(3'd2, 4, 32'hF);
      rr_hit("R11", 4, 4'b1000, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog (all requirements): got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule